// File: doc/BRIEF.md
# Serial word framer with clock burst

This block sits behind a demodulator that already turns line tones into a plain
serial bit stream. Each word on that stream is ten bit times long. It has one low
start bit, eight data bits sent least significant first, and one high stop bit. The
nominal rate is 1202.8 baud, which is the 3.5795 MHz system clock divided by 2976.
The framer finds each word. It passes the bit stream on as `data_out`, forced high
whenever the carrier input says no carrier is present. Next to `data_out` it drives
a burst of exactly eight low-going clock pulses on `dclk_out`, one for each data
bit, and none during the start or stop bit.

A downstream serial-to-parallel shift register captures `data_out` on each rising
edge of `dclk_out`. Each rising edge is placed at the middle of a data bit as seen
on `data_out`. After the eighth rising edge, the active-low strobe `rdy_n` goes low
for half a bit time so that the assembled byte can be latched. Bit timing comes from
a phase counter that restarts on each detected high-to-low input transition. A start
bit that is no longer low at its middle is treated as a glitch, and the word is
dropped.

Top module: `async_word_framer`

## Requirements
- R1: A synchronous active-high `rst` sets `dclk_out`, `rdy_n` and `data_out` to 1 on the next clock edge and abandons any word in progress, including one stopped midway through its data bits.
- R2: A word starts only on a high-to-low transition of `rx_in` while no word is in progress. A line that stays high, or stays low, gives no pulses. One bit time is BIT_DIV clock cycles, with HALF = BIT_DIV/2.
- R3: The start bit is confirmed by sampling it low HALF cycles after the transition is detected. If `rx_in` was low for HALF+1 cycles or fewer, the word is dropped with no `dclk_out` pulse and no `rdy_n` pulse. If it was low for HALF+2 cycles, the word is accepted.
- R4: Every accepted word gives exactly N_BITS (8) low pulses on `dclk_out`, and `dclk_out` stays high during the start and stop bits.
- R5: Each `dclk_out` pulse is low for exactly HALF cycles. Let edge E0 be the clock edge on which `rx_in` is first sampled low. The rising edge for data bit k (k = 1..8) then falls on edge E0 + k·BIT_DIV + HALF + 2.
- R6: While `carrier_ok` is 1, `data_out` follows `rx_in` 2 cycles later. Sampling `data_out` on each rising edge of `dclk_out` recovers the data bits in the order sent (first sampled bit = byte bit 0).
- R7: While `carrier_ok` is 0, `data_out` is 1 from the next cycle on. `dclk_out` still pulses 8 times per word, so the shift register captures 0xFF.
- R8: `rdy_n` falls on edge E0 + 8·BIT_DIV + HALF + 3, which is one cycle after the last `dclk_out` rising edge. It then stays low for HALF cycles.
- R9: If a high-to-low transition of `rx_in` is detected while `rdy_n` is low, `rdy_n` returns high on the following edge. For a stop bit that goes low at its start, the low time is BIT_DIV − HALF − 2 cycles.
- R10: Words sent back to back, each start bit directly after the previous stop bit, are each framed with their own burst and `rdy_n` pulse.
- R11: `dclk_out` and `rdy_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (3.5795 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Demodulated serial bit stream; 1 = mark, 0 = space |
| carrier_ok | input | 1 | 1 while a carrier is present; 0 forces `data_out` high |
| data_out | output | 1 | Gated, re-timed serial data |
| dclk_out | output | 1 | Idles high; one low pulse per data bit, rising at mid-bit |
| rdy_n | output | 1 | Active-low end-of-word strobe |

## Verification
On every cycle, the checker enforces the following. A low `dclk_out` only occurs in the data-bit phase. Every rising edge falls at the mid-bit phase value. Each `rdy_n` pulse comes after exactly eight rising edges and lasts at most half a bit. `dclk_out` and `rdy_n` never overlap. Carrier loss forces `data_out` high, and reset returns all three outputs high.

Only the bench scenarios can show the following. Exact edge positions relative to the input transition, and the captured byte values across all 256 patterns. The glitch-length boundary at HALF+1 versus HALF+2 low cycles. The early release of `rdy_n` on a low stop bit. Back-to-back framing, and recovery from a reset in mid-word.

// File: rtl/awf_pkg.sv
package awf_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } fr_state_t;
endpackage

// File: rtl/awf_rx_front.sv
// Input front end: resynchronisation chain, fall detector and carrier gating.
module awf_rx_front #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  input  logic carrier_ok,
  output logic rx_bit,
  output logic rx_fall,
  output logic data_out
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   data_q;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= rx_in;
        end
      end else begin : g_chain
        always_ff @(posedge clk) begin
          if (rst) sync_q[gi] <= 1'b1;
          else     sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign rx_bit = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      data_q <= 1'b1;
    end else begin
      prev_q <= rx_bit;
      data_q <= carrier_ok ? rx_bit : 1'b1;
    end
  end

  assign rx_fall  = prev_q & ~rx_bit;
  assign data_out = data_q;
endmodule

// File: rtl/awf_frame_ctl.sv
// Frame controller: bit phase counter, bit index and word state.
module awf_frame_ctl
  import awf_pkg::*;
#(
  parameter int BIT_DIV = 2976,
  parameter int N_BITS  = 8,
  localparam int PH_W   = $clog2(BIT_DIV),
  localparam int IDX_W  = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_bit,
  input  logic             rx_fall,
  output fr_state_t        state,
  output logic [PH_W-1:0]  phase,
  output logic [IDX_W-1:0] idx
);
  localparam logic [PH_W-1:0]  PH_HALF = PH_W'(BIT_DIV / 2);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(BIT_DIV - 1);
  localparam logic [IDX_W-1:0] IX_LAST = IDX_W'(N_BITS - 1);

  logic bit_end;
  assign bit_end = (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_IDLE;
      phase <= '0;
      idx   <= '0;
    end else begin
      case (state)
        FR_IDLE: begin
          phase <= '0;
          idx   <= '0;
          if (rx_fall) state <= FR_START;
        end
        FR_START: begin
          if (phase == PH_HALF && rx_bit) begin
            state <= FR_IDLE;
            phase <= '0;
          end else if (bit_end) begin
            state <= FR_DATA;
            phase <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        FR_DATA: begin
          if (bit_end) begin
            phase <= '0;
            if (idx == IX_LAST) state <= FR_STOP;
            else                idx   <= idx + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        FR_STOP: begin
          if (phase == PH_HALF) begin
            state <= FR_IDLE;
            phase <= '0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/awf_strobe_gen.sv
// Strobe generator: registered clock burst and end-of-word ready strobe.
module awf_strobe_gen
  import awf_pkg::*;
#(
  parameter int BIT_DIV = 2976,
  parameter int N_BITS  = 8,
  localparam int PH_W   = $clog2(BIT_DIV),
  localparam int IDX_W  = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  fr_state_t        state,
  input  logic [PH_W-1:0]  phase,
  input  logic [IDX_W-1:0] idx,
  input  logic             rx_fall,
  output logic             dclk_out,
  output logic             rdy_n
);
  localparam logic [PH_W-1:0]  PH_HALF = PH_W'(BIT_DIV / 2);
  localparam logic [PH_W-1:0]  PH_RDY  = PH_W'(BIT_DIV / 2 + 1);
  localparam logic [PH_W-1:0]  HOLD_END = PH_W'(BIT_DIV / 2 - 1);
  localparam logic [IDX_W-1:0] IX_LAST = IDX_W'(N_BITS - 1);

  logic            dclk_q;
  logic            rdy_q;
  logic [PH_W-1:0] hold_cnt;
  logic            pulse_low;
  logic            rdy_set;

  assign pulse_low = (state == FR_DATA) && (phase < PH_HALF);
  assign rdy_set   = (state == FR_DATA) && (idx == IX_LAST) && (phase == PH_RDY);

  always_ff @(posedge clk) begin
    if (rst) dclk_q <= 1'b1;
    else     dclk_q <= ~pulse_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (rdy_set) begin
      rdy_q    <= 1'b0;
      hold_cnt <= '0;
    end else if (!rdy_q) begin
      if (rx_fall || hold_cnt == HOLD_END) rdy_q <= 1'b1;
      else                                 hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign dclk_out = dclk_q;
  assign rdy_n    = rdy_q;
endmodule

// File: rtl/async_word_framer.sv
// Top: serial word framer producing gated data, mid-bit clock burst and ready strobe.
module async_word_framer
  import awf_pkg::*;
#(
  parameter int BIT_DIV     = 2976,
  parameter int N_BITS      = 8,
  parameter int SYNC_STAGES = 1,
  localparam int PH_W       = $clog2(BIT_DIV),
  localparam int IDX_W      = (N_BITS > 1) ? $clog2(N_BITS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  input  logic carrier_ok,
  output logic data_out,
  output logic dclk_out,
  output logic rdy_n
);
  logic             rx_bit;
  logic             rx_fall;
  fr_state_t        fr_state;
  logic [PH_W-1:0]  fr_phase;
  logic [IDX_W-1:0] fr_idx;

  awf_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .rx_in(rx_in), .carrier_ok(carrier_ok),
    .rx_bit(rx_bit), .rx_fall(rx_fall), .data_out(data_out)
  );

  awf_frame_ctl #(.BIT_DIV(BIT_DIV), .N_BITS(N_BITS)) u_ctl (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_fall(rx_fall),
    .state(fr_state), .phase(fr_phase), .idx(fr_idx)
  );

  awf_strobe_gen #(.BIT_DIV(BIT_DIV), .N_BITS(N_BITS)) u_strobe (
    .clk(clk), .rst(rst), .state(fr_state), .phase(fr_phase), .idx(fr_idx),
    .rx_fall(rx_fall), .dclk_out(dclk_out), .rdy_n(rdy_n)
  );
endmodule

// File: rtl/async_word_framer_chk.sv
module async_word_framer_chk
  import awf_pkg::*;
#(
  parameter int BIT_DIV = 2976,
  parameter int N_BITS  = 8,
  localparam int PH_W   = $clog2(BIT_DIV)
) (
  input logic            clk,
  input logic            rst,
  input logic            carrier_ok,
  input logic            data_out,
  input logic            dclk_out,
  input logic            rdy_n,
  input fr_state_t       state,
  input logic [PH_W-1:0] phase,
  input logic            rx_fall
);
  localparam int HALF = BIT_DIV / 2;

  logic          dclk_prev;
  logic [7:0]    rise_cnt;
  logic [PH_W:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_prev <= 1'b1;
      rise_cnt  <= '0;
      low_cnt   <= '0;
    end else begin
      dclk_prev <= dclk_out;
      if (state == FR_IDLE && rx_fall) rise_cnt <= '0;
      else if (dclk_out && !dclk_prev) rise_cnt <= rise_cnt + 1'b1;
      low_cnt <= rdy_n ? '0 : low_cnt + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (dclk_out && rdy_n && data_out));

  // R4
  no_framing_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !dclk_out |-> state == FR_DATA);

  // R4
  burst_count_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n) |-> rise_cnt == 8'(N_BITS));

  // R5
  midbit_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk_out) |-> $past(phase) == PH_W'(HALF));

  // R7
  carrier_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !carrier_ok |=> data_out);

  // R8
  rdy_width_chk: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= (PH_W+1)'(HALF));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    dclk_out || rdy_n);
endmodule

bind async_word_framer async_word_framer_chk #(.BIT_DIV(BIT_DIV), .N_BITS(N_BITS)) u_chk (
  .clk(clk), .rst(rst), .carrier_ok(carrier_ok), .data_out(data_out),
  .dclk_out(dclk_out), .rdy_n(rdy_n), .state(fr_state), .phase(fr_phase),
  .rx_fall(rx_fall)
);

// File: tb/async_word_framer_test.sv
module async_word_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 16;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1;
  logic carrier_ok = 1'b1;
  logic data_out, dclk_out, rdy_n;

  async_word_framer #(.BIT_DIV(DIV), .N_BITS(8), .SYNC_STAGES(1)) uut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .carrier_ok(carrier_ok),
    .data_out(data_out), .dclk_out(dclk_out), .rdy_n(rdy_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int n_checks = 0;
  int n_fail = 0;

  // monitor state
  logic       p_dclk = 1'b1, p_rdy = 1'b1, p_car = 1'b1;
  logic [7:0] shreg = 8'h00;
  logic [7:0] cap_byte = 8'h00;
  int rise_cnt = 0, cur_low = 0, width_err = 0;
  int first_rise = -1, last_rise = -1, rdy_fall = -1;
  int rdy_low = 0, rdy_len = -1, rdy_words = 0;
  int both_low = 0, car_viol = 0;
  int t0 = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!dclk_out) cur_low = cur_low + 1;
      if (dclk_out && !p_dclk) begin
        if (cur_low != HALF) width_err = width_err + 1;
        cur_low = 0;
        shreg = {data_out, shreg[7:1]};
        if (rise_cnt == 0) first_rise = cyc - t0;
        last_rise = cyc - t0;
        rise_cnt = rise_cnt + 1;
      end
      if (!rdy_n) rdy_low = rdy_low + 1;
      if (!rdy_n && p_rdy) begin
        rdy_fall = cyc - t0;
        cap_byte = shreg;
        rdy_words = rdy_words + 1;
      end
      if (rdy_n && !p_rdy) begin
        rdy_len = rdy_low;
        rdy_low = 0;
      end
      if (!dclk_out && !rdy_n) both_low = both_low + 1;
      if (!p_car && !carrier_ok && !data_out) car_viol = car_viol + 1;
    end
    p_dclk = dclk_out;
    p_rdy = rdy_n;
    p_car = carrier_ok;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    rise_cnt = 0; cur_low = 0; width_err = 0;
    first_rise = -1; last_rise = -1; rdy_fall = -1;
    rdy_len = -1; rdy_words = 0; shreg = 8'h00; cap_byte = 8'h00;
    t0 = cyc;
  endtask

  task automatic send_word(input logic [7:0] b, input logic stop_v);
    clear_stats();
    rx_in = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rx_in = b[k];
      repeat (DIV) @(negedge clk);
    end
    rx_in = stop_v;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic check_word(input logic [7:0] exp_b, input string tag);
    chk(rise_cnt == 8, {tag, " R4 pulse count"}, rise_cnt, 8);
    chk(cap_byte == exp_b, {tag, " R6 captured byte"}, int'(cap_byte), int'(exp_b));
    chk(width_err == 0, {tag, " R5 pulse width errors"}, width_err, 0);
    chk(first_rise == DIV + HALF + 3, {tag, " R5 first rise"}, first_rise, DIV + HALF + 3);
    chk(last_rise == 8*DIV + HALF + 3, {tag, " R5 last rise"}, last_rise, 8*DIV + HALF + 3);
    chk(rdy_fall == 8*DIV + HALF + 4, {tag, " R8 rdy fall"}, rdy_fall, 8*DIV + HALF + 4);
    chk(rdy_len == HALF, {tag, " R8 rdy width"}, rdy_len, HALF);
    chk(rdy_words == 1, {tag, " R10 one strobe per word"}, rdy_words, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks = n_checks + 1;
    n_fail = n_fail + 1;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dclk_out == 1'b1, "R1 reset dclk", int'(dclk_out), 1);
    chk(rdy_n == 1'b1, "R1 reset rdy", int'(rdy_n), 1);
    chk(data_out == 1'b1, "R1 reset data", int'(data_out), 1);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2: steady high line
    clear_stats();
    repeat (3*DIV) @(negedge clk);
    chk(rise_cnt == 0, "R2 idle high no pulses", rise_cnt, 0);

    // R3: glitch of HALF+1 cycles is dropped
    clear_stats();
    rx_in = 1'b0;
    repeat (HALF + 1) @(negedge clk);
    rx_in = 1'b1;
    repeat (11*DIV) @(negedge clk);
    chk(rise_cnt == 0, "R3 short glitch pulses", rise_cnt, 0);
    chk(rdy_words == 0, "R3 short glitch rdy", rdy_words, 0);

    // R3: HALF+2 low cycles is accepted, rest of line high
    clear_stats();
    rx_in = 1'b0;
    repeat (HALF + 2) @(negedge clk);
    rx_in = 1'b1;
    repeat (11*DIV) @(negedge clk);
    chk(rise_cnt == 8, "R3 boundary start accepted", rise_cnt, 8);
    chk(cap_byte == 8'hFF, "R3 boundary byte", int'(cap_byte), 255);

    // R6 and R10: all byte values, back to back
    for (int v = 0; v < 256; v++) begin
      send_word(8'(v), 1'b1);
      check_word(8'(v), "sweep");
    end
    repeat (2*DIV) @(negedge clk);

    // R7: carrier absent gates data but not the burst
    carrier_ok = 1'b0;
    repeat (2) @(negedge clk);
    car_viol = 0;
    send_word(8'h00, 1'b1);
    chk(cap_byte == 8'hFF, "R7 gated byte", int'(cap_byte), 255);
    chk(rise_cnt == 8, "R7 gated pulse count", rise_cnt, 8);
    chk(car_viol == 0, "R7 data low while gated", car_viol, 0);
    carrier_ok = 1'b1;
    repeat (2*DIV) @(negedge clk);

    // R9: stop bit low releases rdy_n early
    send_word(8'h80, 1'b0);
    chk(rdy_len == DIV - HALF - 2, "R9 early release width", rdy_len, DIV - HALF - 2);
    chk(cap_byte == 8'h80, "R9 byte", int'(cap_byte), 128);
    // R2: line held low gives no new word
    clear_stats();
    repeat (3*DIV) @(negedge clk);
    chk(rise_cnt == 0, "R2 held low no pulses", rise_cnt, 0);
    rx_in = 1'b1;
    repeat (2*DIV) @(negedge clk);

    // R1: reset in mid-word
    clear_stats();
    rx_in = 1'b0;
    repeat (3*DIV + 2) @(negedge clk);
    rst = 1'b1;
    rx_in = 1'b1;
    @(negedge clk);
    chk(dclk_out == 1'b1, "R1 mid-word reset dclk", int'(dclk_out), 1);
    chk(rdy_n == 1'b1, "R1 mid-word reset rdy", int'(rdy_n), 1);
    chk(data_out == 1'b1, "R1 mid-word reset data", int'(data_out), 1);
    rst = 1'b0;
    clear_stats();
    repeat (10*DIV) @(negedge clk);
    chk(rise_cnt == 0, "R1 no burst after reset", rise_cnt, 0);
    send_word(8'hA5, 1'b1);
    check_word(8'hA5, "post-reset");

    chk(both_low == 0, "R11 dclk and rdy overlap", both_low, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule